// File: doc/BRIEF.md
# Watchdog Timer with Two-Stage Tick Divider

This block is a watchdog peripheral. Software reaches it through a small register port with separate read and write strobes and a word address. The input clock first passes through a programmable prescaler with a ratio from 1 to 256. A fixed divider of 16, 32, 64 or 128 follows it. The resulting tick counts a 16-bit down-counter. When the counter runs out, it reloads from a reload register. If reset generation is enabled, the block also drives a system reset pulse of fixed length.

Software keeps the system alive by writing the counter register periodically. This write is the "kick". It loads a fresh count and restarts the divider chain. The reload register is locked while the timer runs. Clearing both enable bits disarms the watchdog. To force an immediate system reset, software writes a count of 1 and then sets both enable bits.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register reads 0 and both the reload register (offset 0x4) and the counter register (offset 0x8) read 0x8000. The reset output is low.
- R2: The control register at offset 0x0 reads back every field: reset-enable at bit 0, clock-select at bits 4:3, timer-enable at bit 5 and prescaler at bits 15:8. All other bits read 0.
- R3: While the timer-enable bit is set, one counter tick occurs every (prescaler+1) * (16 << clock-select) input clocks. The first tick comes that many clocks after the enabling write.
- R4: Each tick lowers the counter by one. On the tick that finds the counter at 1 or 0, the counter expires and reloads from the reload register. A loaded count of N (N >= 1) therefore expires on the N-th tick, and a count of 0 expires on the first tick.
- R5: On expiry with the reset-enable bit set, the reset output goes high in the cycle after the expiring edge and stays high for exactly 4 input clocks. Without reset-enable, expiry produces no pulse.
- R6: A write to the reload register takes effect only while the timer-enable bit is clear. While the timer-enable bit is set, such a write is ignored.
- R7: A write to the counter register loads the written value and clears both divider stages. The next tick therefore follows one full tick period after that write.
- R8: Clearing the timer-enable bit freezes the counter and clears both divider stages. Re-enabling the timer gives a full tick period before the next decrement.
- R9: Once both enable bits are cleared, no reset pulse is produced.
- R10: Writing 1 to the counter and then writing both enable bits produces a reset pulse exactly one tick period after the enabling write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; also feeds the divider chain |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; 0 when no read is strobed |
| sys_rst_o | output | 1 | System reset pulse, active high |

## Verification
The tick period is measured from a count of 1 with several prescaler and clock-select pairs. These are (0,0), (0,1), (0,3), (2,0), (4,2) and (255,0). Each pair separates a fault in one divider stage from a fault in the other. A count of 3 with reset disabled shows the one-per-tick decrement, the reload on expiry and the absence of a pulse. A count of 0 shows expiry on the first tick. A kick placed partway through a period tells a restarted divider apart from a free-running one. Disabling the timer mid-period and re-enabling it shows the freeze and the full restart period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   // Register byte offsets
   localparam int OFF_CTRL   = 'h0;
   localparam int OFF_RELOAD = 'h4;
   localparam int OFF_COUNT  = 'h8;
   // Control field positions
   localparam int RSTEN_BIT  = 0;
   localparam int SEL_LSB    = 3;
   localparam int EN_BIT     = 5;
   localparam int PSC_LSB    = 8;
endpackage

// File: rtl/wdog_prescale.sv
// Two-stage tick divider: programmable (psc+1), then 2^(BASE_LOG2+sel).
module wdog_prescale #(
   parameter int PSC_W         = 8,
   parameter int SEL_W         = 2,
   parameter int DIV_BASE_LOG2 = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PSC_W-1:0] psc,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int MAX_SEL = (1 << SEL_W) - 1;
   localparam int DIV_W   = DIV_BASE_LOG2 + MAX_SEL;

   logic [PSC_W-1:0] pre_q;
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] div_lim;
   logic             pre_hit;

   always_comb begin
      div_lim = {DIV_W{1'b1}} >> (MAX_SEL - int'(sel));
      pre_hit = run && (pre_q == psc);
      tick    = pre_hit && (div_q == div_lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         div_q <= '0;
      end else if (!run || restart) begin
         pre_q <= '0;
         div_q <= '0;
      end else begin
         pre_q <= pre_hit ? '0 : pre_q + 1'b1;
         if (pre_hit)
            div_q <= (div_q == div_lim) ? '0 : div_q + 1'b1;
      end
   end
endmodule

// File: rtl/wdog_counter.sv
// Down-counter with software load and reload on expiry.
module wdog_counter #(
   parameter int               CNT_W      = 16,
   parameter logic [CNT_W-1:0] RESET_LOAD = 16'h8000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   assign expire = tick && !load && (count <= CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= RESET_LOAD;
      else if (load)
         count <= load_val;
      else if (expire)
         count <= reload;
      else if (tick)
         count <= count - 1'b1;
   end
endmodule

// File: rtl/wdog_rstpulse.sv
// Fixed-length reset pulse generator.
module wdog_rstpulse #(
   parameter int PULSE_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse
);
   generate
      if (PULSE_LEN == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse <= 1'b0;
            else        pulse <= fire;
         end
      end else begin : g_count
         localparam int PW = $clog2(PULSE_LEN + 1);
         logic [PW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               left_q <= '0;
            else if (fire)            left_q <= PW'(PULSE_LEN);
            else if (left_q != '0)    left_q <= left_q - 1'b1;
         end
         assign pulse = (left_q != '0);
      end
   endgenerate
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdog_pkg::*;
#(
   parameter int               DATA_W        = 32,
   parameter int               ADDR_W        = 4,
   parameter int               CNT_W         = 16,
   parameter int               PSC_W         = 8,
   parameter int               SEL_W         = 2,
   parameter int               DIV_BASE_LOG2 = 4,
   parameter int               PULSE_LEN     = 4,
   parameter logic [CNT_W-1:0] RESET_LOAD    = 16'h8000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              sys_rst_o
);
   // Elaboration-time parameter checks
   generate
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W exceeds DATA_W");
      end
      if (PSC_LSB + PSC_W > DATA_W) begin : g_bad_psc
         $error("prescaler field exceeds DATA_W");
      end
      if (SEL_LSB + SEL_W > EN_BIT) begin : g_bad_sel
         $error("clock-select field overlaps enable bit");
      end
      if (PULSE_LEN < 1) begin : g_bad_pulse
         $error("PULSE_LEN must be at least 1");
      end
   endgenerate

   logic             ctrl_en, ctrl_rst_en;
   logic [SEL_W-1:0] ctrl_sel;
   logic [PSC_W-1:0] ctrl_psc;
   logic [CNT_W-1:0] reload_q, cnt_q;
   logic             wr_ctrl, wr_reload, wr_count;
   logic             tick, expire;
   logic             unused_wdata;

   assign unused_wdata = ^wdata;

   always_comb begin
      wr_ctrl   = wr_en && (addr == ADDR_W'(OFF_CTRL));
      wr_reload = wr_en && (addr == ADDR_W'(OFF_RELOAD));
      wr_count  = wr_en && (addr == ADDR_W'(OFF_COUNT));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en     <= 1'b0;
         ctrl_rst_en <= 1'b0;
         ctrl_sel    <= '0;
         ctrl_psc    <= '0;
         reload_q    <= RESET_LOAD;
      end else begin
         if (wr_ctrl) begin
            ctrl_en     <= wdata[EN_BIT];
            ctrl_rst_en <= wdata[RSTEN_BIT];
            ctrl_sel    <= wdata[SEL_LSB +: SEL_W];
            ctrl_psc    <= wdata[PSC_LSB +: PSC_W];
         end
         if (wr_reload && !ctrl_en)
            reload_q <= wdata[CNT_W-1:0];
      end
   end

   wdog_prescale #(
      .PSC_W(PSC_W), .SEL_W(SEL_W), .DIV_BASE_LOG2(DIV_BASE_LOG2)
   ) u_div (
      .clk(clk), .rst_n(rst_n), .run(ctrl_en), .restart(wr_count),
      .psc(ctrl_psc), .sel(ctrl_sel), .tick(tick)
   );

   wdog_counter #(
      .CNT_W(CNT_W), .RESET_LOAD(RESET_LOAD)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(wr_count), .load_val(wdata[CNT_W-1:0]),
      .tick(tick), .reload(reload_q), .count(cnt_q), .expire(expire)
   );

   wdog_rstpulse #(
      .PULSE_LEN(PULSE_LEN)
   ) u_pulse (
      .clk(clk), .rst_n(rst_n), .fire(expire && ctrl_rst_en), .pulse(sys_rst_o)
   );

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (addr == ADDR_W'(OFF_CTRL)) begin
            rdata[RSTEN_BIT]          = ctrl_rst_en;
            rdata[EN_BIT]             = ctrl_en;
            rdata[SEL_LSB +: SEL_W]   = ctrl_sel;
            rdata[PSC_LSB +: PSC_W]   = ctrl_psc;
         end else if (addr == ADDR_W'(OFF_RELOAD)) begin
            rdata[CNT_W-1:0] = reload_q;
         end else if (addr == ADDR_W'(OFF_COUNT)) begin
            rdata[CNT_W-1:0] = cnt_q;
         end
      end
   end
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
   import wdog_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter int CNT_W     = 16,
   parameter int PULSE_LEN = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              sys_rst_o,
   input logic              ctrl_en,
   input logic              ctrl_rst_en,
   input logic [CNT_W-1:0]  reload_q,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              tick
);
   logic [15:0] run_len;
   logic        kick;

   assign kick = wr_en && (addr == ADDR_W'(OFF_COUNT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         run_len <= '0;
      else if (sys_rst_o) run_len <= run_len + 1'b1;
      else                run_len <= '0;
   end

   a_r3_tick_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> ctrl_en);

   a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt_q > CNT_W'(1) && !kick) |=> (cnt_q == $past(cnt_q) - 1'b1));

   a_r5_pulse_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_o) |-> $past(ctrl_en && ctrl_rst_en));

   a_r5_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_rst_o) |-> ($past(run_len) == 16'(PULSE_LEN - 1)));

   a_r6_reload_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFF_RELOAD) && ctrl_en) |=> $stable(reload_q));

   a_r7_kick_loads: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> (cnt_q == $past(wdata[CNT_W-1:0])));

   a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_en && !kick) |=> $stable(cnt_q));
endmodule

bind wdog_timer wdog_timer_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .sys_rst_o(sys_rst_o), .ctrl_en(ctrl_en), .ctrl_rst_en(ctrl_rst_en),
   .reload_q(reload_q), .cnt_q(cnt_q), .tick(tick)
);

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        sys_rst;
   int          checks = 0;
   int          fails = 0;

   always #4 clk = ~clk;

   wdog_timer uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .sys_rst_o(sys_rst)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      rd_en = 1'b1; addr = a;
      #1;
      v = rdata;
      rd_en = 1'b0;
   endtask

   // Cycles after the last write edge until the reset output is seen high; 0 if never
   task automatic meas(input int maxc, output int n);
      int k = 0;
      n = 0;
      while (k < maxc) begin
         @(negedge clk);
         k++;
         if (sys_rst) begin n = k; break; end
      end
   endtask

   task automatic width(output int w);
      w = 1;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (sys_rst) w++; else break;
      end
   endtask

   task automatic quiet(input int n, input string req);
      int hi = 0;
      repeat (n) begin
         @(negedge clk);
         if (sys_rst) hi++;
      end
      check(req, hi, 0);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      do_reset();
      rd(4'h0, v); check("R1 ctrl", v, 32'h0);
      rd(4'h4, v); check("R1 reload", v, 32'h8000);
      rd(4'h8, v); check("R1 count", v, 32'h8000);
      check("R1 sys_rst", {31'b0, sys_rst}, 32'h0);
   endtask

   task automatic t_fields();
      logic [31:0] v;
      do_reset();
      wr(4'h0, 32'h5A5A_ABDF);
      rd(4'h0, v); check("R2 fields", v, 32'h0000_AB19);
   endtask

   task automatic t_force();
      int n, w;
      do_reset();
      wr(4'h8, 32'd1);
      wr(4'h0, 32'h21);
      meas(100, n); check("R10 forced delay", n, 16);
      width(w);     check("R5 pulse width", w, 4);
   endtask

   task automatic t_zero();
      int n;
      do_reset();
      wr(4'h8, 32'd0);
      wr(4'h0, 32'h21);
      meas(100, n); check("R4 zero count", n, 16);
   endtask

   task automatic t_period(input int psc, input int sel, input int exp);
      int n;
      do_reset();
      wr(4'h8, 32'd1);
      wr(4'h0, (psc << 8) | (sel << 3) | 32'h21);
      meas(exp + 50, n);
      check($sformatf("R3 period psc=%0d sel=%0d", psc, sel), n, exp);
   endtask

   task automatic t_countdown();
      logic [31:0] v;
      do_reset();
      wr(4'h4, 32'd5);
      rd(4'h4, v); check("R6 reload accepted", v, 32'd5);
      wr(4'h8, 32'd3);
      wr(4'h0, 32'h20);
      repeat (20) @(negedge clk);
      rd(4'h8, v); check("R4 decrement", v, 32'd2);
      quiet(35, "R5 no pulse without reset-enable");
      rd(4'h8, v); check("R4 reload on expiry", v, 32'd5);
      wr(4'h4, 32'h1234);
      rd(4'h4, v); check("R6 reload locked", v, 32'd5);
   endtask

   task automatic t_kick();
      int n;
      do_reset();
      wr(4'h8, 32'd2);
      wr(4'h0, 32'h21);
      quiet(24, "R7 before kick");
      wr(4'h8, 32'd2);
      meas(100, n); check("R7 kick restarts", n, 32);
   endtask

   task automatic t_freeze();
      logic [31:0] v;
      do_reset();
      wr(4'h8, 32'd4);
      wr(4'h0, 32'h20);
      repeat (20) @(negedge clk);
      rd(4'h8, v); check("R8 running", v, 32'd3);
      wr(4'h0, 32'h0);
      repeat (100) @(negedge clk);
      rd(4'h8, v); check("R8 frozen", v, 32'd3);
      wr(4'h0, 32'h20);
      repeat (15) @(negedge clk);
      rd(4'h8, v); check("R8 full period pending", v, 32'd3);
      @(negedge clk);
      rd(4'h8, v); check("R8 first tick after re-enable", v, 32'd2);
   endtask

   task automatic t_disarm();
      do_reset();
      wr(4'h8, 32'd2);
      wr(4'h0, 32'h21);
      repeat (10) @(negedge clk);
      wr(4'h0, 32'h0);
      quiet(200, "R9 disarmed");
   endtask

   initial begin
      t_reset();
      t_fields();
      t_force();
      t_zero();
      t_period(0, 1, 32);
      t_period(0, 3, 128);
      t_period(2, 0, 48);
      t_period(4, 2, 320);
      t_period(255, 0, 4096);
      t_countdown();
      t_kick();
      t_freeze();
      t_disarm();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule